// File: doc/BRIEF.md
# Masked vector unsigned-64-to-half-precision converter

The block turns up to eight unsigned 64-bit integers into IEEE 754 binary16 values and packs them into a 128-bit result. A two-bit length code selects how many lanes take part (two, four or eight). A per-lane write mask, with its own enable, decides which lanes receive a fresh conversion. Lanes left out by the mask are either cleared or keep the previous destination contents. When the operand comes from memory and broadcast is requested, element 0 is converted in every lane.

The rounding mode normally comes from a global control field. An instruction-level override replaces it, but only for a register operand at full (eight-lane) length with the override enable set. Converting 64 bits down to 16 overflows easily. An overflowing lane produces infinity or the largest finite value, depending on the rounding direction, and raises both the overflow and the precision flag. A reserved specifier field that is not all ones marks the operation as undefined. In that case the destination is not written and no flag is raised.

The outputs pass through one register stage by default (`REG_OUT`). Each lane's conversion finds the leading one, keeps eleven significant bits and rounds with guard and sticky bits.

Top module: `u2h_vec_cvt`

## Requirements
- R1: `vlen_sel` 2'b00, 2'b01 and 2'b10 give 2, 4 and 8 active lanes. Lane j holds result bits [16j+15:16j] and reads source bits [64j+63:64j]. Code 2'b11 is undefined (see R10).
- R2: An active, written lane holds the binary16 encoding of its unsigned source. The sign bit is 0, the bias is 15 and there are 10 fraction bits. A zero input gives 16'h0000, and inputs up to 2048 convert exactly (2048 gives 16'h6800).
- R3: The rounding mode is selected by code: 2'b00 rounds to nearest with ties to even, 2'b01 rounds toward minus infinity, 2'b10 toward plus infinity and 2'b11 toward zero. For example, 2051 gives 16'h6802 under codes 00 and 10, and 16'h6801 under codes 01 and 11.
- R4: A result whose exponent would exceed 15 after rounding is an overflow. It gives 16'h7C00 under codes 00 and 10, and 16'h7BFF under codes 01 and 11. It sets both `ovf_flag` and `prec_flag`.
- R5: `prec_flag` is set when any written lane's rounded result differs from its exact value.
- R6: A lane is written with the conversion when `mask_en` is 0 or `kmask[j]` is 1. Otherwise it becomes zero when `zeroing` is 1, or keeps `dest_old[16j+15:16j]` when `zeroing` is 0.
- R7: When `src_is_mem` and `bcast` are both 1, every lane converts source element 0. With a register source, `bcast` has no effect.
- R8: `rc_static` replaces `glob_rc` only when `src_is_mem` is 0, `vlen_sel` is 2'b10 and `rc_en` is 1.
- R9: Result bits from 32 × (active lanes) / 2, that is from 16 × (active lanes), up to bit 127 are zero.
- R10: When `rsv_spec` is not 4'hF or `vlen_sel` is 2'b11, `ud` is 1, `dest` equals `dest_old` and both flags are 0.
- R11: The flags are the OR over written lanes only. Masked-off and inactive lanes never raise a flag.
- R12: With `REG_OUT`=1, the outputs appear one clock after the inputs. Reset (active-low `rst_n`) clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| vlen_sel | input | 2 | Vector length code |
| src | input | 512 | Eight unsigned 64-bit source elements |
| kmask | input | 8 | Per-lane write mask |
| mask_en | input | 1 | 1: the write mask applies |
| zeroing | input | 1 | 1: clear unwritten lanes, 0: keep them |
| bcast | input | 1 | Broadcast element 0 (memory source only) |
| src_is_mem | input | 1 | Operand comes from memory |
| rc_en | input | 1 | Enable for the instruction rounding override |
| rc_static | input | 2 | Instruction rounding override code |
| glob_rc | input | 2 | Global rounding mode code |
| dest_old | input | 128 | Previous destination contents |
| rsv_spec | input | 4 | Reserved specifier field, must be 4'hF |
| dest | output | 128 | Packed binary16 result |
| ovf_flag | output | 1 | Overflow in a written lane |
| prec_flag | output | 1 | Inexact result in a written lane |
| ud | output | 1 | Undefined operation |

## Verification
A wrong leading-zero count or rounding increment shows up as a wrong binary16 code in exactly the affected lane, one clock after the operands are applied. A mask or length error shows up as merged, cleared or non-zero upper lanes in that same cycle. Flag errors appear as an overflow without precision, or as a flag raised by a lane that was masked off. Directed overflow and tie cases are followed by randomized operands with varied magnitudes, and every output is compared each cycle against an independent divide-and-compare model.

// File: rtl/u2h_pkg.sv
package u2h_pkg;
   localparam int HALF_W    = 16;
   localparam int HALF_MANT = 10;
   localparam int HALF_BIAS = 15;
   localparam int HALF_EMAX = 15;
   localparam logic [15:0] HALF_PINF   = 16'h7C00;
   localparam logic [15:0] HALF_MAXFIN = 16'h7BFF;

   typedef enum logic [1:0] {
      RND_NEAR = 2'b00,
      RND_DOWN = 2'b01,
      RND_UP   = 2'b10,
      RND_ZERO = 2'b11
   } rnd_t;
endpackage

// File: rtl/u2h_lane_cvt.sv
module u2h_lane_cvt
   import u2h_pkg::*;
#(
   parameter int IN_W = 64
) (
   input  logic [IN_W-1:0]   val,
   input  rnd_t              rm,
   output logic [HALF_W-1:0] res,
   output logic              ovf,
   output logic              inx
);
   localparam int PW  = $clog2(IN_W);
   localparam int EW  = PW + 2;
   localparam int SIG = HALF_MANT + 1;

   logic [PW-1:0]   lz;
   logic [IN_W-1:0] norm;
   logic [SIG-1:0]  mant;
   logic            grd, stk, inc, is_zero, ovf_raw;
   logic [SIG:0]    sum;
   logic [EW-1:0]   expo;
   logic [HALF_MANT-1:0] frac;

   // leading-zero count: the highest set bit wins
   always_comb begin
      lz = '0;
      for (int i = 0; i < IN_W; i++)
         if (val[i]) lz = PW'(IN_W - 1 - i);
   end

   assign is_zero = (val == '0);
   assign norm    = val << lz;
   assign mant    = norm[IN_W-1 -: SIG];
   assign grd     = norm[IN_W-1-SIG];
   assign stk     = |norm[IN_W-2-SIG:0];

   always_comb begin
      unique case (rm)
         RND_NEAR: inc = grd & (stk | mant[0]);
         RND_UP:   inc = grd | stk;
         default:  inc = 1'b0;
      endcase
   end

   assign sum     = {1'b0, mant} + {{SIG{1'b0}}, inc};
   assign expo    = EW'(IN_W - 1) - EW'(lz) + EW'(sum[SIG]);
   assign frac    = sum[SIG] ? sum[SIG-1:1] : sum[SIG-2:0];
   assign ovf_raw = expo > EW'(HALF_EMAX);

   always_comb begin
      if (is_zero)
         res = '0;
      else if (ovf_raw)
         res = (rm == RND_NEAR || rm == RND_UP) ? HALF_PINF : HALF_MAXFIN;
      else
         res = {1'b0, 5'(expo + EW'(HALF_BIAS)), frac};
   end

   assign ovf = !is_zero && ovf_raw;
   assign inx = !is_zero && (grd || stk || ovf_raw);
endmodule

// File: rtl/u2h_lane_mask.sv
module u2h_lane_mask #(
   parameter int EL_W = 16
) (
   input  logic [EL_W-1:0] cvt,
   input  logic [EL_W-1:0] old,
   input  logic            cvt_ovf,
   input  logic            cvt_inx,
   input  logic            active,
   input  logic            write_en,
   input  logic            zero_fill,
   output logic [EL_W-1:0] out,
   output logic            ovf_o,
   output logic            inx_o
);
   logic take;
   assign take = active & write_en;

   always_comb begin
      if (!active)        out = '0;
      else if (write_en)  out = cvt;
      else if (zero_fill) out = '0;
      else                out = old;
   end

   assign ovf_o = take & cvt_ovf;
   assign inx_o = take & cvt_inx;
endmodule

// File: rtl/u2h_vec_cvt.sv
module u2h_vec_cvt
   import u2h_pkg::*;
#(
   parameter int LANES   = 8,
   parameter int IN_W    = 64,
   parameter bit REG_OUT = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [1:0]              vlen_sel,
   input  logic [LANES*IN_W-1:0]   src,
   input  logic [LANES-1:0]        kmask,
   input  logic                    mask_en,
   input  logic                    zeroing,
   input  logic                    bcast,
   input  logic                    src_is_mem,
   input  logic                    rc_en,
   input  logic [1:0]              rc_static,
   input  logic [1:0]              glob_rc,
   input  logic [LANES*HALF_W-1:0] dest_old,
   input  logic [3:0]              rsv_spec,
   output logic [LANES*HALF_W-1:0] dest,
   output logic                    ovf_flag,
   output logic                    prec_flag,
   output logic                    ud
);
   localparam int DW    = LANES * HALF_W;
   localparam int CNT_W = $clog2(LANES) + 2;

   if (LANES != 8) begin : g_bad_lanes
      $error("u2h_vec_cvt: LANES must be 8 for the three length codes");
   end
   if (IN_W < 16 || IN_W > 128) begin : g_bad_width
      $error("u2h_vec_cvt: IN_W must lie in 16..128");
   end

   logic [CNT_W-1:0] n_act;
   rnd_t             rm_sel;
   logic             ud_c, use_bc;
   logic [DW-1:0]    lanes_out, dest_c;
   logic [LANES-1:0] ovf_v, inx_v;
   logic             ovf_c, inx_c;

   assign n_act  = CNT_W'(2) << vlen_sel;
   assign ud_c   = (rsv_spec != 4'hF) || (vlen_sel == 2'b11);
   assign use_bc = src_is_mem & bcast;
   assign rm_sel = rnd_t'((!src_is_mem && vlen_sel == 2'b10 && rc_en) ? rc_static : glob_rc);

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      logic [IN_W-1:0]   opnd;
      logic [HALF_W-1:0] cres;
      logic              covf, cinx;

      assign opnd = use_bc ? src[IN_W-1:0] : src[j*IN_W +: IN_W];

      u2h_lane_cvt #(.IN_W(IN_W)) u_cvt (
         .val (opnd),
         .rm  (rm_sel),
         .res (cres),
         .ovf (covf),
         .inx (cinx)
      );

      u2h_lane_mask #(.EL_W(HALF_W)) u_msk (
         .cvt       (cres),
         .old       (dest_old[j*HALF_W +: HALF_W]),
         .cvt_ovf   (covf),
         .cvt_inx   (cinx),
         .active    (CNT_W'(j) < n_act),
         .write_en  (!mask_en || kmask[j]),
         .zero_fill (zeroing),
         .out       (lanes_out[j*HALF_W +: HALF_W]),
         .ovf_o     (ovf_v[j]),
         .inx_o     (inx_v[j])
      );
   end

   assign dest_c = ud_c ? dest_old : lanes_out;
   assign ovf_c  = !ud_c && (|ovf_v);
   assign inx_c  = !ud_c && (|inx_v);

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dest      <= '0;
            ovf_flag  <= 1'b0;
            prec_flag <= 1'b0;
            ud        <= 1'b0;
         end else begin
            dest      <= dest_c;
            ovf_flag  <= ovf_c;
            prec_flag <= inx_c;
            ud        <= ud_c;
         end
      end
   end else begin : g_comb
      assign dest      = dest_c;
      assign ovf_flag  = ovf_c;
      assign prec_flag = inx_c;
      assign ud        = ud_c;
   end
endmodule

// File: rtl/u2h_vec_chk.sv
module u2h_vec_chk #(
   parameter bit LAT = 1'b1,
   parameter int DW  = 128
) (
   input logic          clk,
   input logic          rst_n,
   input logic [1:0]    vlen_sel,
   input logic [3:0]    rsv_spec,
   input logic [DW-1:0] dest_old,
   input logic          zeroing,
   input logic          mask_en,
   input logic [1:0]    kmask_lo,
   input logic [DW-1:0] dest,
   input logic          ovf_flag,
   input logic          prec_flag,
   input logic          ud
);
   logic [1:0]    vl_d;
   logic [3:0]    rs_d;
   logic [DW-1:0] old_d;
   logic          zr_d, me_d, vld;
   logic [1:0]    k_d;

   if (LAT) begin : g_lat
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vl_d <= 2'b00; rs_d <= 4'hF; old_d <= '0;
            zr_d <= 1'b0; me_d <= 1'b0; k_d <= 2'b11; vld <= 1'b0;
         end else begin
            vl_d <= vlen_sel; rs_d <= rsv_spec; old_d <= dest_old;
            zr_d <= zeroing; me_d <= mask_en; k_d <= kmask_lo; vld <= 1'b1;
         end
      end
   end else begin : g_nolat
      assign vl_d = vlen_sel; assign rs_d = rsv_spec; assign old_d = dest_old;
      assign zr_d = zeroing;  assign me_d = mask_en;  assign k_d = kmask_lo;
      assign vld  = 1'b1;
   end

   AST_OVF_WITH_PREC: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_flag |-> prec_flag); // R4

   AST_UD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && ud) |-> (!ovf_flag && !prec_flag && dest == old_d)); // R10

   AST_UD_ON_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && rs_d != 4'hF) |-> ud); // R10

   AST_UPPER_ZERO_2: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && !ud && vl_d == 2'b00) |-> (dest[DW-1:32] == '0)); // R9

   AST_UPPER_ZERO_4: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && !ud && vl_d == 2'b01) |-> (dest[DW-1:64] == '0)); // R9

   AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && !ud && zr_d && me_d && k_d == 2'b00) |-> (dest[31:0] == '0)); // R6
endmodule

bind u2h_vec_cvt u2h_vec_chk #(.LAT(REG_OUT), .DW(LANES*16)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .vlen_sel  (vlen_sel),
   .rsv_spec  (rsv_spec),
   .dest_old  (dest_old),
   .zeroing   (zeroing),
   .mask_en   (mask_en),
   .kmask_lo  (kmask[1:0]),
   .dest      (dest),
   .ovf_flag  (ovf_flag),
   .prec_flag (prec_flag),
   .ud        (ud)
);

// File: tb/tb_u2h_vec_cvt.sv
module tb_u2h_vec_cvt;
   localparam int LN = 8;
   localparam int QW = 64;
   localparam int DW = 128;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    vlen_sel;
   logic [LN*QW-1:0] src;
   logic [LN-1:0] kmask;
   logic          mask_en, zeroing, bcast, src_is_mem, rc_en;
   logic [1:0]    rc_static, glob_rc;
   logic [DW-1:0] dest_old;
   logic [3:0]    rsv_spec;
   logic [DW-1:0] dest;
   logic          ovf_flag, prec_flag, ud;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   u2h_vec_cvt dut (.*);

   // returns {overflow, inexact, half}
   function automatic logic [17:0] ref_half(input logic [63:0] v, input logic [1:0] rm);
      int p;
      logic [63:0] q, rem, half;
      logic up;
      if (v == 64'd0) return 18'h0;
      p = 0; half = 0; rem = 0;
      for (int i = 0; i < 64; i++) if (v[i]) p = i;
      if (p <= 10) q = v << (10 - p);
      else begin
         q    = v >> (p - 10);
         rem  = v & ((64'd1 << (p - 10)) - 64'd1);
         half = 64'd1 << (p - 11);
      end
      case (rm)
         2'b00:   up = (p > 10) && (rem > half || (rem == half && q[0]));
         2'b10:   up = (rem != 0);
         default: up = 1'b0;
      endcase
      q = q + {63'd0, up};
      if (q == 64'd2048) begin q = 64'd1024; p++; end
      if (p > 15) return {2'b11, (rm == 2'b00 || rm == 2'b10) ? 16'h7C00 : 16'h7BFF};
      return {1'b0, rem != 0, 1'b0, 5'(p + 15), q[9:0]};
   endfunction

   task automatic expect_op(output logic [DW-1:0] ed, output logic eo, output logic ep, output logic eu);
      int n;
      logic [1:0] rm;
      logic [17:0] h;
      eu = (rsv_spec != 4'hF) || (vlen_sel == 2'b11);
      ed = '0; eo = 1'b0; ep = 1'b0;
      if (eu) begin ed = dest_old; return; end
      n  = 2 << vlen_sel;
      rm = (!src_is_mem && vlen_sel == 2'b10 && rc_en) ? rc_static : glob_rc;
      for (int j = 0; j < n; j++) begin
         if (!mask_en || kmask[j]) begin
            h = ref_half((src_is_mem && bcast) ? src[63:0] : src[j*QW +: QW], rm);
            ed[j*16 +: 16] = h[15:0];
            eo |= h[17];
            ep |= h[16];
         end else if (!zeroing)
            ed[j*16 +: 16] = dest_old[j*16 +: 16];
      end
   endtask

   // inputs were just driven after a falling edge; result is read at the next one
   task automatic apply_and_check(input string tag);
      logic [DW-1:0] ed;
      logic eo, ep, eu;
      expect_op(ed, eo, ep, eu);
      @(negedge clk);
      checks++;
      if (dest !== ed || ovf_flag !== eo || prec_flag !== ep || ud !== eu) begin
         errors++;
         $display("FAIL %s dest=%h ovf=%b prec=%b ud=%b expected dest=%h ovf=%b prec=%b ud=%b",
                  tag, dest, ovf_flag, prec_flag, ud, ed, eo, ep, eu);
      end
   endtask

   task automatic chk_lane(input string tag, input int lane, input logic [15:0] exp_v);
      checks++;
      if (dest[lane*16 +: 16] !== exp_v) begin
         errors++;
         $display("FAIL %s lane %0d actual=%h expected=%h", tag, lane, dest[lane*16 +: 16], exp_v);
      end
   endtask

   task automatic chk_bits(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp_v);
      checks++;
      if (act !== exp_v) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
      end
   endtask

   task automatic defaults();
      vlen_sel = 2'b10; src = '0; kmask = '1; mask_en = 1'b0; zeroing = 1'b0;
      bcast = 1'b0; src_is_mem = 1'b0; rc_en = 1'b0; rc_static = 2'b00; glob_rc = 2'b00;
      dest_old = {$urandom, $urandom, $urandom, $urandom} | 128'h1; rsv_spec = 4'hF;
   endtask

   initial begin
      #(200000 * 8);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      defaults();
      repeat (3) @(negedge clk);
      // R12: reset state
      chk_bits("R12 reset dest", dest, '0);
      chk_bits("R12 reset flags", {125'd0, ovf_flag, prec_flag, ud}, '0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: exact values
      src = {64'd7, 64'd1024, 64'd3, 64'd100, 64'd65504, 64'd2048, 64'd1, 64'd0};
      apply_and_check("R2 exact");
      chk_lane("R2 zero", 0, 16'h0000);
      chk_lane("R2 one", 1, 16'h3C00);
      chk_lane("R2 2048", 2, 16'h6800);
      chk_lane("R2 max finite", 3, 16'h7BFF);

      // R3: rounding modes on 2049 (tie, even) and 2051 (tie, odd)
      for (int m = 0; m < 4; m++) begin
         defaults();
         glob_rc = 2'(m);
         src[127:0] = {64'd2051, 64'd2049};
         apply_and_check("R3 rounding modes");
         chk_lane("R3 2051", 1, (m == 0 || m == 2) ? 16'h6802 : 16'h6801);
         chk_lane("R3 2049", 0, (m == 2) ? 16'h6801 : 16'h6800);
      end

      // R4: overflow
      defaults();
      src[255:0] = {64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 64'd65519, 64'd65520};
      apply_and_check("R4 overflow near-even");
      chk_lane("R4 65520 rounds to inf", 0, 16'h7C00);
      chk_lane("R4 65519 rounds down", 1, 16'h7BFF);
      defaults();
      glob_rc = 2'b11;
      src[63:0] = 64'h8000_0000_0000_0000;
      apply_and_check("R4 overflow toward zero");
      chk_lane("R4 saturate", 0, 16'h7BFF);
      chk_bits("R4 flags", {126'd0, ovf_flag, prec_flag}, 128'd3);

      // R5: inexact without overflow
      defaults();
      vlen_sel = 2'b00;
      src[127:0] = {64'd0, 64'd2049};
      apply_and_check("R5 inexact");
      chk_bits("R5 flags", {126'd0, ovf_flag, prec_flag}, 128'd1);

      // R6: merge and zero masking
      for (int z = 0; z < 2; z++) begin
         defaults();
         mask_en = 1'b1; kmask = 8'hA5; zeroing = z[0];
         for (int j = 0; j < LN; j++) src[j*QW +: QW] = 64'(j * 300 + 5);
         apply_and_check("R6 masking");
         chk_lane("R6 masked lane", 1, z[0] ? 16'h0000 : dest_old[31:16]);
      end

      // R7: broadcast from memory, and ignored for a register source
      defaults();
      src_is_mem = 1'b1; bcast = 1'b1;
      for (int j = 0; j < LN; j++) src[j*QW +: QW] = 64'(j + 10);
      apply_and_check("R7 broadcast");
      chk_lane("R7 lane7 takes element0", 7, 16'h4900);
      src_is_mem = 1'b0;
      apply_and_check("R7 register ignores bcast");
      chk_lane("R7 lane7 own element", 7, 16'h4C40);

      // R8: static rounding override
      defaults();
      rc_en = 1'b1; rc_static = 2'b11; glob_rc = 2'b00;
      src[63:0] = 64'd65520;
      apply_and_check("R8 override at 512");
      chk_lane("R8 override used", 0, 16'h7BFF);
      vlen_sel = 2'b01;
      apply_and_check("R8 not at 256");
      chk_lane("R8 global used", 0, 16'h7C00);
      vlen_sel = 2'b10; src_is_mem = 1'b1;
      apply_and_check("R8 not for memory");
      chk_lane("R8 memory uses global", 0, 16'h7C00);

      // R1 / R9: lane counts and upper zeroing
      for (int v = 0; v < 3; v++) begin
         defaults();
         vlen_sel = 2'(v);
         for (int j = 0; j < LN; j++) src[j*QW +: QW] = 64'(j + 1);
         apply_and_check("R1 lane count");
         chk_bits("R9 upper zero", dest >> (32 << v), '0);
         chk_lane("R1 last active lane", (2 << v) - 1, ref_half(64'(2 << v), 2'b00) >> 0);
      end

      // R10: undefined
      defaults();
      rsv_spec = 4'hE; src[63:0] = 64'hFFFF_FFFF_FFFF_FFFF;
      apply_and_check("R10 reserved field");
      chk_bits("R10 dest kept", dest, dest_old);
      defaults();
      vlen_sel = 2'b11;
      apply_and_check("R10 length code 3");

      // R11: masked-off overflowing lane raises nothing
      defaults();
      mask_en = 1'b1; kmask = 8'h02;
      src[127:0] = {64'd5, 64'hFFFF_0000_0000_0000};
      apply_and_check("R11 masked overflow");
      chk_bits("R11 flags quiet", {126'd0, ovf_flag, prec_flag}, '0);

      // R12: one-cycle latency
      defaults();
      src[63:0] = 64'd1;
      apply_and_check("R12 setup");
      src[63:0] = 64'd2;
      #1;
      chk_lane("R12 output held before edge", 0, 16'h3C00);
      apply_and_check("R12 next result");

      // randomized mix
      for (int n = 0; n < 400; n++) begin
         vlen_sel   = ($urandom % 16 == 0) ? 2'b11 : 2'($urandom % 3);
         for (int j = 0; j < LN; j++)
            src[j*QW +: QW] = {$urandom, $urandom} >> ($urandom % 64);
         kmask      = 8'($urandom);
         mask_en    = 1'($urandom);
         zeroing    = 1'($urandom);
         bcast      = 1'($urandom);
         src_is_mem = 1'($urandom);
         rc_en      = 1'($urandom);
         rc_static  = 2'($urandom);
         glob_rc    = 2'($urandom);
         dest_old   = {$urandom, $urandom, $urandom, $urandom};
         rsv_spec   = ($urandom % 16 == 0) ? 4'($urandom) : 4'hF;
         apply_and_check("R2 R6 random");
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule